// File: doc/BRIEF.md
# Discrete-Input Sensor SPI Register Target

This block is the host-facing register port of a 32-channel discrete-input threshold sensor. A host talks to it over a four-wire SPI link in mode 0, which means the clock idles low, input is sampled on the rising edge and output changes after it. The block runs on its own system clock and oversamples the SPI pins. Every transaction begins with a command byte. Its top bit selects the direction and its lower seven bits name a register. Data bytes follow the command byte, most significant byte first.

The register set covers several pieces of state:
- a control register, with a test-mode bit and a two-step soft reset;
- a sensing-mode register that holds one bit per bank of eight channels;
- a test-pattern byte;
- two 16-bit threshold registers, one for ground-open sensing and one for supply-open sensing. Each holds a hysteresis byte above a centre byte.

The live channel inputs are synchronized and sampled every cycle. They can be read one bank at a time as a byte, or all together as a 32-bit word.

An odd hysteresis value written to either threshold register puts the device into a locked state. The block models this with a sticky flag. While the flag is set, input sampling stops. Only a soft reset or a hardware reset clears the flag.

Top module: `dsense_spi_regs`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6..0 carry the register address. Bytes the host sends after a read command never modify any register.
- R2: Read data is shifted out on MISO, most significant bit first. The first data bit is presented after the eighth rising SCK edge of the command byte. Eight-bit registers return 1 byte, threshold registers return 2 bytes and the word alias returns 4 bytes. Any further bytes read as 0x00.
- R3: A write to an 8-bit register takes effect after one data byte. A write to a threshold register (0x3A or 0x3C) takes effect after two data bytes, with the high byte sent first.
- R4: The registers read back what was written to them:
  - control at 0x02: bit 0 is test mode, bit 1 is soft reset;
  - sensing mode at 0x04: bit b selects supply-open (1) or ground-open (0) for bank b, low 4 bits;
  - test pattern at 0x1E: 8 bits;
  - ground-open threshold at 0x3A and supply-open threshold at 0x3C: 16 bits each, hysteresis in bits 15..8 and centre in bits 7..0.
- R5: Bank b of the inputs (channels 8b+7..8b) reads as one byte at address 0x10+2b. Address 0x78 returns all inputs as a 4-byte word, in which bit i is channel i.
- R6: A control write with bit 1 = 0, made while the stored control bit 1 is 1, performs a soft reset. The soft reset clears control, sensing mode, test pattern, both thresholds and the lock flag.
- R7: A threshold write whose hysteresis is odd (bit 8 of the written word = 1) sets the `locked` output. The flag stays set until a soft or hardware reset. While it is set, the sampled inputs do not change.
- R8: While control bit 0 is 1, every bank reads the test-pattern byte instead of its inputs.
- R9: Reads from unmapped addresses return 0x00. Writes to unmapped or read-only addresses change nothing.
- R10: Raising CS_N aborts the transaction. A write that has not received all of its data bytes does not commit. MISO is 0 while CS_N is high and during the command byte.
- R11: After a hardware reset, all registers read 0 and `locked` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host, MSB first |
| sense_in | input | 32 | Live discrete channel inputs, bit i = channel i |
| locked | output | 1 | Sticky lock flag raised by an odd hysteresis write |

## Verification
Assertions check every cycle that the lock flag stays set once raised and that the sampled inputs hold still while it is set. They also check that an odd hysteresis commit raises the flag, that a soft reset clears the whole register set, that no write commits while chip select is high, and that MISO stays low both while chip select is high and during the command byte. Only the bench's scenarios can show the rest:
- the byte framing and big-endian ordering of multi-byte reads;
- the address decode of the bank and word aliases;
- test-mode substitution;
- that aborted partial writes leave the registers as they were;
- that a frozen input snapshot is released by the two-step soft reset.

// File: rtl/dsense_pkg.sv
package dsense_pkg;
  // Register addresses: the host decodes these, so they are fixed.
  localparam logic [6:0] A_CTRL    = 7'h02;
  localparam logic [6:0] A_MODE    = 7'h04;
  localparam logic [6:0] A_BANK0   = 7'h10;
  localparam logic [6:0] A_TPAT    = 7'h1E;
  localparam logic [6:0] A_THR_GND = 7'h3A;
  localparam logic [6:0] A_THR_SUP = 7'h3C;
  localparam logic [6:0] A_WORD    = 7'h78;

  localparam int BYTE_W        = 8;
  localparam int CTRL_W        = 2;
  localparam int CTRL_TEST_BIT = 0;
  localparam int CTRL_SRST_BIT = 1;
  localparam int THR_W         = 16;
  localparam int HYS_LSB_BIT   = 8;   // hysteresis parity bit of a threshold word
  localparam int RD_CMD_BIT    = 7;

  function automatic logic is_wide(input logic [6:0] a);
    return (a == A_THR_GND) || (a == A_THR_SUP);
  endfunction
endpackage

// File: rtl/dsense_sync.sv
module dsense_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= (s == 0) ? d : stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dsense_rx.sv
module dsense_rx #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             cs_n_s,
  input  logic             mosi_s,
  output logic             active,
  output logic             sck_rise,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] byte_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             sck_d_q;
  logic [2:0]       bit_cnt_q, bit_cnt_n;
  logic [6:0]       sh_q, sh_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  assign active    = !cs_n_s;
  assign sck_rise  = active && sck_s && !sck_d_q;
  assign byte_done = sck_rise && (bit_cnt_q == 3'd7);
  assign rx_byte   = {sh_q, mosi_s};
  assign byte_idx  = idx_q;

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    sh_n      = sh_q;
    idx_n     = idx_q;
    if (!active) begin
      bit_cnt_n = '0;
      idx_n     = '0;
    end else if (sck_rise) begin
      bit_cnt_n = bit_cnt_q + 3'd1;
      sh_n      = {sh_q[5:0], mosi_s};
      if (bit_cnt_q == 3'd7 && idx_q != IDX_MAX) idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q   <= 1'b0;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
    end else begin
      sck_d_q   <= sck_s;
      bit_cnt_q <= bit_cnt_n;
      sh_q      <= sh_n;
      idx_q     <= idx_n;
    end
  end
endmodule

// File: rtl/dsense_regs.sv
module dsense_regs
  import dsense_pkg::*;
#(
  parameter int CH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH-1:0]    sense_s,
  input  logic             wr_en,
  input  logic [6:0]       wr_addr,
  input  logic [THR_W-1:0] wr_data,
  input  logic [6:0]       rd_addr,
  output logic [CH-1:0]    rd_word,
  output logic             locked
);
  localparam int NBANK = CH / BYTE_W;

  logic [CTRL_W-1:0] ctrl_q,  ctrl_n;
  logic [NBANK-1:0]  mode_q,  mode_n;
  logic [BYTE_W-1:0] tpat_q,  tpat_n;
  logic [THR_W-1:0]  thr_g_q, thr_g_n;
  logic [THR_W-1:0]  thr_s_q, thr_s_n;
  logic              lock_q,  lock_n;
  logic [CH-1:0]     sense_q, samp_src;
  logic              soft_rst;

  assign soft_rst = wr_en && (wr_addr == A_CTRL) &&
                    ctrl_q[CTRL_SRST_BIT] && !wr_data[CTRL_SRST_BIT];

  always_comb begin
    ctrl_n  = ctrl_q;
    mode_n  = mode_q;
    tpat_n  = tpat_q;
    thr_g_n = thr_g_q;
    thr_s_n = thr_s_q;
    lock_n  = lock_q;
    if (soft_rst) begin
      ctrl_n  = '0;
      mode_n  = '0;
      tpat_n  = '0;
      thr_g_n = '0;
      thr_s_n = '0;
      lock_n  = 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_n = wr_data[CTRL_W-1:0];
        A_MODE: mode_n = wr_data[NBANK-1:0];
        A_TPAT: tpat_n = wr_data[BYTE_W-1:0];
        A_THR_GND: begin
          thr_g_n = wr_data;
          if (wr_data[HYS_LSB_BIT]) lock_n = 1'b1;
        end
        A_THR_SUP: begin
          thr_s_n = wr_data;
          if (wr_data[HYS_LSB_BIT]) lock_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Per-bank sample source: test pattern replaces the inputs in test mode.
  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign samp_src[b*BYTE_W +: BYTE_W] =
        ctrl_q[CTRL_TEST_BIT] ? tpat_q : sense_s[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      tpat_q  <= '0;
      thr_g_q <= '0;
      thr_s_q <= '0;
      lock_q  <= 1'b0;
      sense_q <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      mode_q  <= mode_n;
      tpat_q  <= tpat_n;
      thr_g_q <= thr_g_n;
      thr_s_q <= thr_s_n;
      lock_q  <= lock_n;
      if (!lock_q) sense_q <= samp_src;
    end
  end

  // Read data, left-aligned so the shifter always starts at the MSB.
  always_comb begin
    rd_word = '0;
    case (rd_addr)
      A_CTRL:    rd_word[CH-1 -: BYTE_W] = BYTE_W'(ctrl_q);
      A_MODE:    rd_word[CH-1 -: BYTE_W] = BYTE_W'(mode_q);
      A_TPAT:    rd_word[CH-1 -: BYTE_W] = tpat_q;
      A_THR_GND: rd_word[CH-1 -: THR_W]  = thr_g_q;
      A_THR_SUP: rd_word[CH-1 -: THR_W]  = thr_s_q;
      A_WORD:    rd_word                 = sense_q;
      default: ;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (rd_addr == A_BANK0 + 7'(2*b)) rd_word[CH-1 -: BYTE_W] = sense_q[b*BYTE_W +: BYTE_W];
    end
  end

  assign locked = lock_q;

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !soft_rst) |=> lock_q);
  p_frozen_inputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(sense_q));
  p_odd_hys_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_wide(wr_addr) && wr_data[HYS_LSB_BIT]) |=> lock_q);
  p_soft_reset_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == '0 && mode_q == '0 && tpat_q == '0 &&
                  thr_g_q == '0 && thr_s_q == '0 && !lock_q));
endmodule

// File: rtl/dsense_spi_regs.sv
module dsense_spi_regs
  import dsense_pkg::*;
#(
  parameter int CH          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic [CH-1:0] sense_in,
  output logic          locked
);
  localparam int IDX_W = 2;

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  logic sck_s, cs_n_s, mosi_s;
  dsense_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_ns), .d({sck, cs_n, mosi}), .q({sck_s, cs_n_s, mosi_s}));

  logic [CH-1:0] sense_s;
  dsense_sync #(.W(CH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sense_sync (
    .clk(clk), .rst_n(rst_ns), .d(sense_in), .q(sense_s));

  logic             active, sck_rise, byte_done;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] byte_idx;
  dsense_rx #(.IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_ns), .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .active(active), .sck_rise(sck_rise), .byte_done(byte_done),
    .rx_byte(rx_byte), .byte_idx(byte_idx));

  logic [7:0]       cmd_q, cmd_n;
  logic [7:0]       hi_q,  hi_n;
  logic [CH-1:0]    tx_q,  tx_n;
  logic             wide, wr_en;
  logic [THR_W-1:0] wr_data;
  logic [CH-1:0]    rd_word;

  assign wide    = is_wide(cmd_q[6:0]);
  assign wr_en   = byte_done && !cmd_q[RD_CMD_BIT] &&
                   ((byte_idx == 2'd1 && !wide) || (byte_idx == 2'd2 && wide));
  assign wr_data = wide ? {hi_q, rx_byte} : {8'h00, rx_byte};

  dsense_regs #(.CH(CH)) u_regs (
    .clk(clk), .rst_n(rst_ns), .sense_s(sense_s),
    .wr_en(wr_en), .wr_addr(cmd_q[6:0]), .wr_data(wr_data),
    .rd_addr(rx_byte[6:0]), .rd_word(rd_word), .locked(locked));

  always_comb begin
    cmd_n = cmd_q;
    hi_n  = hi_q;
    tx_n  = tx_q;
    if (!active) begin
      tx_n = '0;
    end else if (byte_done && byte_idx == 2'd0) begin
      cmd_n = rx_byte;
      tx_n  = rx_byte[RD_CMD_BIT] ? rd_word : '0;
    end else if (sck_rise) begin
      tx_n = {tx_q[CH-2:0], 1'b0};
    end
    if (byte_done && byte_idx == 2'd1) hi_n = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cmd_q <= '0;
      hi_q  <= '0;
      tx_q  <= '0;
    end else begin
      cmd_q <= cmd_n;
      hi_q  <= hi_n;
      tx_q  <= tx_n;
    end
  end

  assign miso = tx_q[CH-1];

  p_no_commit_idle_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |-> !cs_n_s);
  p_miso_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    cs_n_s |=> !miso);
  p_miso_quiet_cmd_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && byte_idx == 2'd0) |-> !miso);
  p_read_no_write_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_q[RD_CMD_BIT] |-> !wr_en);
endmodule

// File: tb/sim_dsense_spi_regs.sv
module sim_dsense_spi_regs;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, mosi, miso, locked;
  logic [31:0] sense_in;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dsense_spi_regs u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
                      .miso(miso), .sense_in(sense_in), .locked(locked));

  typedef struct packed {
    logic [1:0]  op;   // 0 read, 1 write 8-bit, 2 write 16-bit
    logic [7:0]  addr;
    logic [2:0]  nb;
    logic [31:0] val;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h02, 3'd1, 32'h0,        4'd11}, // R11 control after reset
    '{2'd0, 8'h04, 3'd1, 32'h0,        4'd11}, // R11 mode after reset
    '{2'd0, 8'h3C, 3'd2, 32'h0,        4'd11}, // R11 threshold after reset
    '{2'd1, 8'h04, 3'd1, 32'h0A,       4'd4},  // R1 write command, R4 mode
    '{2'd0, 8'h04, 3'd1, 32'h0A,       4'd1},  // R1 read with 0xFF filler leaves it
    '{2'd2, 8'h3A, 3'd2, 32'h0206,     4'd3},  // R3 two-byte write
    '{2'd0, 8'h3A, 3'd2, 32'h0206,     4'd3},
    '{2'd2, 8'h3C, 3'd2, 32'h0410,     4'd3},
    '{2'd0, 8'h3C, 3'd2, 32'h0410,     4'd4},
    '{2'd0, 8'h10, 3'd1, 32'h81,       4'd5},  // R5 bank 0
    '{2'd0, 8'h12, 3'd1, 32'h0F,       4'd5},
    '{2'd0, 8'h14, 3'd1, 32'hC3,       4'd5},
    '{2'd0, 8'h16, 3'd1, 32'hA5,       4'd5},
    '{2'd0, 8'h78, 3'd4, 32'hA5C30F81, 4'd2},  // R2 big-endian word
    '{2'd0, 8'h3A, 3'd4, 32'h02060000, 4'd2},  // R2 trailing zero bytes
    '{2'd0, 8'h20, 3'd1, 32'h0,        4'd9},  // R9 unmapped
    '{2'd0, 8'h11, 3'd1, 32'h0,        4'd9},
    '{2'd1, 8'h12, 3'd1, 32'hFF,       4'd9},  // R9 read-only write
    '{2'd0, 8'h12, 3'd1, 32'h0F,       4'd9},
    '{2'd1, 8'h1E, 3'd1, 32'h5A,       4'd4},
    '{2'd0, 8'h1E, 3'd1, 32'h5A,       4'd4},
    '{2'd1, 8'h02, 3'd1, 32'h01,       4'd8},  // R8 test mode on
    '{2'd0, 8'h02, 3'd1, 32'h01,       4'd8},
    '{2'd0, 8'h78, 3'd4, 32'h5A5A5A5A, 4'd8},
    '{2'd1, 8'h02, 3'd1, 32'h00,       4'd8},
    '{2'd0, 8'h10, 3'd1, 32'h81,       4'd8}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int rq, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic spi_read(input logic [7:0] addr, input int nb, output logic [31:0] v);
    logic [7:0] b;
    v = '0;
    cs_begin();
    spi_byte(addr | 8'h80, b);
    for (int k = 0; k < nb; k++) begin
      spi_byte(8'hFF, b);
      v = {v[23:0], b};
    end
    cs_end();
  endtask

  task automatic spi_write(input logic [7:0] addr, input logic [15:0] d, input logic wide);
    logic [7:0] b;
    cs_begin();
    spi_byte(addr & 8'h7F, b);
    if (wide) spi_byte(d[15:8], b);
    spi_byte(d[7:0], b);
    cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    sense_in = 32'hA5C3_0F81;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({31'b0, locked}, 32'h0, 11, "lock after reset");
    chk({31'b0, miso}, 32'h0, 10, "miso idle");

    for (int n = 0; n < NV; n++) begin
      if (VEC[n].op == 2'd0) begin
        spi_read(VEC[n].addr, int'(VEC[n].nb), v);
        chk(v, VEC[n].val, int'(VEC[n].rq), $sformatf("vector %0d read %h", n, VEC[n].addr));
      end else begin
        spi_write(VEC[n].addr, VEC[n].val[15:0], VEC[n].op == 2'd2);
      end
    end

    // R10: threshold write cut after its high byte does not commit
    cs_begin();
    spi_byte(8'h3A, b);
    spi_byte(8'hFF, b);
    cs_end();
    spi_read(8'h3A, 2, v);
    chk(v, 32'h0206, 10, "aborted threshold write");

    // R10: mode write cut mid-byte does not commit, and framing restarts
    cs_begin();
    spi_byte(8'h04, b);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    cs_end();
    spi_read(8'h04, 1, v);
    chk(v, 32'h0A, 10, "aborted mode write");

    // R7: odd hysteresis locks and freezes the inputs
    spi_write(8'h3A, 16'h0306, 1'b1);
    chk({31'b0, locked}, 32'h1, 7, "lock after odd hysteresis");
    sense_in = 32'h1234_5678;
    repeat (20) @(negedge clk);
    spi_read(8'h78, 4, v);
    chk(v, 32'hA5C30F81, 7, "inputs frozen while locked");
    spi_write(8'h04, 16'h0003, 1'b0);
    chk({31'b0, locked}, 32'h1, 7, "lock sticky across writes");

    // R6: two-step soft reset
    spi_write(8'h02, 16'h0002, 1'b0);
    chk({31'b0, locked}, 32'h1, 6, "lock held while reset bit set");
    spi_write(8'h02, 16'h0000, 1'b0);
    chk({31'b0, locked}, 32'h0, 6, "lock cleared by soft reset");
    spi_read(8'h3A, 2, v);  chk(v, 32'h0, 6, "gnd threshold cleared");
    spi_read(8'h3C, 2, v);  chk(v, 32'h0, 6, "sup threshold cleared");
    spi_read(8'h04, 1, v);  chk(v, 32'h0, 6, "mode cleared");
    spi_read(8'h1E, 1, v);  chk(v, 32'h0, 6, "test pattern cleared");
    spi_read(8'h78, 4, v);  chk(v, 32'h12345678, 6, "sampling resumed");

    // R11: hardware reset clears a lock
    spi_write(8'h3C, 16'h0110, 1'b1);
    chk({31'b0, locked}, 32'h1, 7, "lock via supply threshold");
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({31'b0, locked}, 32'h0, 11, "lock after hardware reset");
    spi_read(8'h3C, 2, v);  chk(v, 32'h0, 11, "threshold after hardware reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule